// File: doc/BRIEF.md
# Dual-Channel Transmit Byte Queue with Interrupt Status

This block holds two transmit byte queues. Software loads both through one 32-bit data register, and a select register steers each write to one of the queues. Each channel has its own length register and its own start register. A start drains the configured number of bytes from that channel's queue onto a byte stream with a valid/ready handshake, then empties the queue. When the channel finishes, its bit in the interrupt status register is set.

The same interrupt enable and status registers also record a receive event from a neighbouring receive path. A single level interrupt line is high while any enabled status bit is set. A soft-reset bit in the control register returns every register and queue to its reset state.

Top module: `dual_tx_fifo_irq`

## Requirements
- R1: After reset, every readable register reads 0, `irq` is low and `tx_valid` is low.
- R2: A write of N to the select register (address 0x01) selects channel N when N is below the channel count (2). Any other value selects channel 0. The register reads back the channel that is selected.
- R3: A write to the length register of channel n (address 0x10+2n) stores the value, except that a value above the queue size of 4096 bytes is stored as 4096.
- R4: A write to the data register (address 0x02) appends its four bytes to the selected channel's queue, bits 7:0 first and bits 31:24 last. The write is discarded when the queue has fewer than 4 bytes free, and the bytes already queued stay unchanged.
- R5: A write with bit 0 set to the start register of channel n (address 0x11+2n) starts that channel only when control bit 1 (transmit enable, address 0x00) is set and the channel's length is not zero. Otherwise nothing is sent and no status bit changes.
- R6: A started channel sends the smaller of its length and the number of bytes it holds, oldest byte first. Each byte is transferred when `tx_valid` and `tx_ready` are both high. `tx_last` marks the final byte, and `tx_chan` gives the channel number.
- R7: When a channel completes, its queue is emptied, its length reads 0 and bit n of the status register (address 0x04) is set. This also happens when the queue held no bytes, and in that case no byte is emitted.
- R8: Each 1 written to the status register clears that bit. A pulse on `rx_event` sets status bit 8. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: `irq` is high exactly when the status register AND the enable register (address 0x03) is non-zero.
- R10: A control write with bit 0 set clears the select, length, enable and status registers and both queues, and abandons any transfer. The control register keeps the other written bits, and bit 0 reads back as 0.
- R11: While a channel is waiting or sending, a start, a length write or a data write aimed at that channel is ignored. A start on the other channel is queued and is served after the current frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rx_event | input | 1 | Receive-complete pulse; sets status bit 8 |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_chan | output | 1 | Channel that owns the byte |

## Verification
On every cycle, the assertions check that a stalled byte is held steady, that the cycle after a final byte carries no valid byte, and that a completed frame raises its status bit. They also check that a status write clears the bits written as 1, that a receive pulse sets bit 8, that a soft reset silences the interrupt and the stream, and that the select and fill levels stay in range. Only the bench scenarios can show the byte order and the contents of a frame, the truncation to the bytes actually held, the discarding of a write to a full queue, the length clamp, the start gating, and the queuing of a second channel behind a busy one.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
   // register word addresses
   localparam logic [5:0] ADR_CTRL    = 6'h00;
   localparam logic [5:0] ADR_SEL     = 6'h01;
   localparam logic [5:0] ADR_DATA    = 6'h02;
   localparam logic [5:0] ADR_IEN     = 6'h03;
   localparam logic [5:0] ADR_ISTAT   = 6'h04;
   localparam logic [5:0] ADR_CH_BASE = 6'h10; // len at base+2n, start at base+2n+1

   localparam int CTL_SRST = 0;
   localparam int CTL_TXEN = 1;

   localparam int IRQ_W  = 9;
   localparam int IRQ_RX = 8;

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_SEND = 1'b1
   } eng_state_e;
endpackage

// File: rtl/dtx_chan_fifo.sv
module dtx_chan_fifo #(
   parameter  int FIFO_BYTES = 4096,
   localparam int WORDS      = FIFO_BYTES / 4,
   localparam int AW         = $clog2(WORDS),
   localparam int LW         = $clog2(FIFO_BYTES) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [31:0]   wdata,
   input  logic          pop,
   output logic [7:0]    head,
   output logic [LW-1:0] used,
   output logic          room
);
   if ((FIFO_BYTES & (FIFO_BYTES - 1)) != 0 || FIFO_BYTES < 8) begin : g_bad_size
      $error("dtx_chan_fifo: FIFO_BYTES must be a power of two of at least 8");
   end

   logic [31:0]   mem_q [WORDS];
   logic [AW-1:0] wp_q, rp_q;
   logic [1:0]    bsel_q;
   logic [LW-1:0] cnt_q;
   logic          push_ok;

   assign room    = cnt_q <= LW'(FIFO_BYTES - 4);
   assign push_ok = push && room && !flush;
   assign used    = cnt_q;
   assign head    = mem_q[rp_q][8*bsel_q +: 8];

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q   <= '0;
         rp_q   <= '0;
         bsel_q <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         wp_q   <= '0;
         rp_q   <= '0;
         bsel_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + AW'(1);
         if (pop) begin
            bsel_q <= bsel_q + 2'd1;
            if (bsel_q == 2'd3) rp_q <= rp_q + AW'(1);
         end
         cnt_q <= cnt_q + (push_ok ? LW'(4) : LW'(0)) - (pop ? LW'(1) : LW'(0));
      end
   end
endmodule

// File: rtl/dtx_sender.sv
module dtx_sender
   import dtx_pkg::*;
#(
   parameter  int NUM_CH     = 2,
   parameter  int FIFO_BYTES = 4096,
   localparam int LW         = $clog2(FIFO_BYTES) + 1,
   localparam int CHW        = $clog2(NUM_CH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic [NUM_CH-1:0]          start,
   input  logic [NUM_CH-1:0][LW-1:0]  len,
   input  logic [NUM_CH-1:0][LW-1:0]  used,
   input  logic [NUM_CH-1:0][7:0]     head,
   output logic [NUM_CH-1:0]          pop,
   output logic [NUM_CH-1:0]          done,
   output logic [NUM_CH-1:0]          busy,
   output logic                       tx_valid,
   input  logic                       tx_ready,
   output logic [7:0]                 tx_data,
   output logic                       tx_last,
   output logic [CHW-1:0]             tx_chan
);
   eng_state_e        st_q;
   logic [CHW-1:0]    cur_q;
   logic [LW-1:0]     rem_q;
   logic [NUM_CH-1:0] pend_q;

   logic [CHW-1:0]    pick;
   logic              found;
   logic [LW-1:0]     eff;
   logic              beat;

   // lowest-numbered waiting channel wins
   always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend_q[i]) begin
            pick  = CHW'(i);
            found = 1'b1;
         end
      end
   end

   assign eff  = (len[pick] < used[pick]) ? len[pick] : used[pick];
   assign beat = (st_q == ENG_SEND) && tx_ready;

   always_comb begin
      done = '0;
      pop  = '0;
      busy = pend_q;
      if (st_q == ENG_SEND) busy[cur_q] = 1'b1;
      if (st_q == ENG_IDLE && found && eff == '0) done[pick] = 1'b1;
      if (beat) begin
         pop[cur_q] = 1'b1;
         if (rem_q == LW'(1)) done[cur_q] = 1'b1;
      end
   end

   assign tx_valid = (st_q == ENG_SEND);
   assign tx_data  = head[cur_q];
   assign tx_last  = (rem_q == LW'(1));
   assign tx_chan  = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         cur_q  <= '0;
         rem_q  <= '0;
         pend_q <= '0;
      end else if (clr) begin
         st_q   <= ENG_IDLE;
         cur_q  <= '0;
         rem_q  <= '0;
         pend_q <= '0;
      end else begin
         logic [NUM_CH-1:0] nxt_pend;
         nxt_pend = pend_q | start;
         case (st_q)
            ENG_IDLE: begin
               if (found) begin
                  nxt_pend[pick] = 1'b0;
                  if (eff != '0) begin
                     st_q  <= ENG_SEND;
                     cur_q <= pick;
                     rem_q <= eff;
                  end
               end
            end
            ENG_SEND: begin
               if (beat) begin
                  rem_q <= rem_q - LW'(1);
                  if (rem_q == LW'(1)) st_q <= ENG_IDLE;
               end
            end
            default: st_q <= ENG_IDLE;
         endcase
         pend_q <= nxt_pend;
      end
   end
endmodule

// File: rtl/dtx_regs.sv
module dtx_regs
   import dtx_pkg::*;
#(
   parameter  int NUM_CH     = 2,
   parameter  int FIFO_BYTES = 4096,
   localparam int LW         = $clog2(FIFO_BYTES) + 1,
   localparam int CHW        = $clog2(NUM_CH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic [5:0]                 addr,
   input  logic [31:0]                wdata,
   output logic [31:0]                rdata,
   input  logic [NUM_CH-1:0]          busy,
   input  logic [NUM_CH-1:0]          done,
   input  logic                       rx_event,
   output logic                       soft_clr,
   output logic                       push,
   output logic [CHW-1:0]             sel,
   output logic [NUM_CH-1:0][LW-1:0]  len,
   output logic [NUM_CH-1:0]          start,
   output logic [IRQ_W-1:0]           istat,
   output logic                       irq
);
   logic [31:0]      ctrl_q;
   logic [CHW-1:0]   sel_q;
   logic [IRQ_W-1:0] ien_q, istat_q, set_vec, clr_vec;
   logic [LW-1:0]    len_q [NUM_CH];
   logic [NUM_CH-1:0] len_wr, go_wr;

   assign soft_clr = wr && addr == ADR_CTRL && wdata[CTL_SRST];
   assign push     = wr && addr == ADR_DATA;
   assign sel      = sel_q;
   assign istat    = istat_q;
   assign irq      = |(istat_q & ien_q);

   always_comb begin
      set_vec              = '0;
      set_vec[NUM_CH-1:0]  = done;
      set_vec[IRQ_RX]      = rx_event;
      clr_vec              = (wr && addr == ADR_ISTAT) ? wdata[IRQ_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         sel_q   <= '0;
         ien_q   <= '0;
         istat_q <= '0;
      end else if (soft_clr) begin
         ctrl_q  <= wdata & ~(32'd1 << CTL_SRST);
         sel_q   <= '0;
         ien_q   <= '0;
         istat_q <= '0;
      end else begin
         if (wr && addr == ADR_CTRL) ctrl_q <= wdata;
         if (wr && addr == ADR_SEL)
            sel_q <= (wdata < 32'(NUM_CH)) ? wdata[CHW-1:0] : '0;
         if (wr && addr == ADR_IEN) ien_q <= wdata[IRQ_W-1:0];
         istat_q <= (istat_q & ~clr_vec) | set_vec;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [5:0] LEN_ADR = ADR_CH_BASE + 6'(2 * c);
      assign len_wr[c] = wr && addr == LEN_ADR;
      assign go_wr[c]  = wr && addr == LEN_ADR + 6'd1;
      assign start[c]  = go_wr[c] && wdata[0] && ctrl_q[CTL_TXEN]
                         && len_q[c] != '0 && !busy[c];
      assign len[c]    = len_q[c];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     len_q[c] <= '0;
         else if (soft_clr || done[c])   len_q[c] <= '0;
         else if (len_wr[c] && !busy[c])
            len_q[c] <= (wdata > 32'(FIFO_BYTES)) ? LW'(FIFO_BYTES) : wdata[LW-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADR_CTRL:  rdata = ctrl_q;
         ADR_SEL:   rdata = 32'(sel_q);
         ADR_IEN:   rdata = 32'(ien_q);
         ADR_ISTAT: rdata = 32'(istat_q);
         default:   rdata = '0;
      endcase
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == ADR_CH_BASE + 6'(2 * c)) rdata = 32'(len_q[c]);
      end
   end
endmodule

// File: rtl/dual_tx_fifo_irq.sv
module dual_tx_fifo_irq
   import dtx_pkg::*;
#(
   parameter  int NUM_CH     = 2,
   parameter  int FIFO_BYTES = 4096,
   localparam int LW         = $clog2(FIFO_BYTES) + 1,
   localparam int CHW        = $clog2(NUM_CH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr,
   input  logic [5:0]     reg_addr,
   input  logic [31:0]    reg_wdata,
   output logic [31:0]    reg_rdata,
   input  logic           rx_event,
   output logic           irq,
   output logic           tx_valid,
   input  logic           tx_ready,
   output logic [7:0]     tx_data,
   output logic           tx_last,
   output logic [CHW-1:0] tx_chan
);
   if (NUM_CH < 2 || NUM_CH > IRQ_RX) begin : g_bad_ch
      $error("dual_tx_fifo_irq: NUM_CH must lie between 2 and 8");
   end

   logic                      soft_clr, push_any;
   logic [CHW-1:0]            sel_w;
   logic [NUM_CH-1:0][LW-1:0] len_w, used_w;
   logic [NUM_CH-1:0][7:0]    head_w;
   logic [NUM_CH-1:0]         start_w, busy_w, done_w, pop_w, room_w;
   logic [IRQ_W-1:0]          istat_w;

   dtx_regs #(.NUM_CH(NUM_CH), .FIFO_BYTES(FIFO_BYTES)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .busy     (busy_w),
      .done     (done_w),
      .rx_event (rx_event),
      .soft_clr (soft_clr),
      .push     (push_any),
      .sel      (sel_w),
      .len      (len_w),
      .start    (start_w),
      .istat    (istat_w),
      .irq      (irq)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_q
      logic push_c;
      assign push_c = push_any && sel_w == CHW'(c) && !busy_w[c];
      dtx_chan_fifo #(.FIFO_BYTES(FIFO_BYTES)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .flush (soft_clr || done_w[c]),
         .push  (push_c),
         .wdata (reg_wdata),
         .pop   (pop_w[c]),
         .head  (head_w[c]),
         .used  (used_w[c]),
         .room  (room_w[c])
      );
   end

   dtx_sender #(.NUM_CH(NUM_CH), .FIFO_BYTES(FIFO_BYTES)) u_send (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_clr),
      .start    (start_w),
      .len      (len_w),
      .used     (used_w),
      .head     (head_w),
      .pop      (pop_w),
      .done     (done_w),
      .busy     (busy_w),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .tx_data  (tx_data),
      .tx_last  (tx_last),
      .tx_chan  (tx_chan)
   );
endmodule

// File: rtl/dtx_checks.sv
module dtx_checks
   import dtx_pkg::*;
#(
   parameter  int NUM_CH     = 2,
   parameter  int FIFO_BYTES = 4096,
   localparam int LW         = $clog2(FIFO_BYTES) + 1,
   localparam int CHW        = $clog2(NUM_CH)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      reg_wr,
   input logic [5:0]                reg_addr,
   input logic [31:0]               reg_wdata,
   input logic                      rx_event,
   input logic                      irq,
   input logic                      tx_valid,
   input logic                      tx_ready,
   input logic [7:0]                tx_data,
   input logic                      tx_last,
   input logic [CHW-1:0]            tx_chan,
   input logic [IRQ_W-1:0]          istat,
   input logic [NUM_CH-1:0]         done,
   input logic [NUM_CH-1:0][LW-1:0] used,
   input logic [CHW-1:0]            sel
);
   logic srst_wr, beat;
   assign srst_wr = reg_wr && reg_addr == ADR_CTRL && reg_wdata[CTL_SRST];
   assign beat    = tx_valid && tx_ready;

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !srst_wr |=> tx_valid && $stable(tx_data)
                                            && $stable(tx_last) && $stable(tx_chan)); // R6
   AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      beat && tx_last |=> !tx_valid); // R6
   AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      beat && tx_last && !srst_wr |=> istat[$past(tx_chan)]); // R7
   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_addr == ADR_ISTAT && !rx_event && done == '0
      |=> (istat & $past(reg_wdata[IRQ_W-1:0])) == '0); // R8
   AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event && !srst_wr |=> istat[IRQ_RX]); // R8
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      istat == '0 |-> !irq); // R9
   AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      srst_wr |=> !irq && !tx_valid && istat == '0); // R10
   AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sel) < 32'(NUM_CH)); // R2

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lvl
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         used[c] <= LW'(FIFO_BYTES)); // R4
   end
endmodule

bind dual_tx_fifo_irq dtx_checks #(.NUM_CH(NUM_CH), .FIFO_BYTES(FIFO_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .rx_event  (rx_event),
   .irq       (irq),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_data   (tx_data),
   .tx_last   (tx_last),
   .tx_chan   (tx_chan),
   .istat     (istat_w),
   .done      (done_w),
   .used      (used_w),
   .sel       (sel_w)
);

// File: tb/dual_tx_fifo_irq_tb_top.sv
module dual_tx_fifo_irq_tb_top;
   localparam logic [5:0] A_CTRL = 6'h00, A_SEL = 6'h01, A_DATA = 6'h02,
                          A_IEN = 6'h03, A_STAT = 6'h04;
   localparam logic [5:0] A_LEN0 = 6'h10, A_GO0 = 6'h11, A_LEN1 = 6'h12, A_GO1 = 6'h13;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0, rx_event = 1'b0, tx_ready = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        irq, tx_valid, tx_last;
   logic [7:0]  tx_data;
   logic [0:0]  tx_chan;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;
   logic [7:0] got [0:4199];
   int chan_err;

   always #2.5ns clk = ~clk;

   dual_tx_fifo_irq dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_event(rx_event),
      .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_last(tx_last), .tx_chan(tx_chan)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = a;
      #1ns d = reg_rdata;
   endtask

   function automatic logic [31:0] pw(input logic [7:0] b);
      return {b + 8'd3, b + 8'd2, b + 8'd1, b};
   endfunction

   task automatic push_words(input logic [7:0] base, input int nw);
      for (int k = 0; k < nw; k++) wr(A_DATA, pw(8'(base + 4 * k)));
   endtask

   task automatic pulse_rx();
      @(negedge clk); rx_event = 1'b1;
      @(negedge clk); rx_event = 1'b0;
   endtask

   // collect one frame; returns byte count and whether tx_last was seen
   task automatic recv(input bit stall, input int exp_chan, output int n, output bit fin);
      int cyc = 0;
      n = 0; fin = 1'b0; chan_err = 0;
      while (!fin && cyc < 20000) begin
         @(negedge clk); cyc++;
         tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
         #1ns;
         if (tx_valid && tx_ready) begin
            got[n] = tx_data;
            if (32'(tx_chan) != exp_chan) chan_err++;
            n++;
            if (tx_last) fin = 1'b1;
         end
      end
      @(negedge clk); tx_ready = 1'b0;
   endtask

   task automatic pattern_errs(input logic [7:0] base, input int n, output int e);
      e = 0;
      for (int j = 0; j < n; j++) if (got[j] !== 8'(base + j)) e++;
   endtask

   // watch the stream for a number of cycles with tx_ready high
   task automatic quiet(input int cycles, output int seen);
      seen = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk); tx_ready = 1'b1;
         #1ns if (tx_valid) seen++;
      end
      @(negedge clk); tx_ready = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(A_CTRL, d); chk("R1 ctrl", d, 0);
      rd(A_SEL, d);  chk("R1 sel", d, 0);
      rd(A_LEN0, d); chk("R1 len0", d, 0);
      rd(A_LEN1, d); chk("R1 len1", d, 0);
      rd(A_IEN, d);  chk("R1 ien", d, 0);
      rd(A_STAT, d); chk("R1 stat", d, 0);
      chk("R1 irq", irq, 0);
      chk("R1 tx_valid", tx_valid, 0);
   endtask

   task automatic t_select();
      logic [31:0] d;
      wr(A_SEL, 1); rd(A_SEL, d); chk("R2 sel=1", d, 1);
      wr(A_SEL, 5); rd(A_SEL, d); chk("R2 sel=5->0", d, 0);
      wr(A_SEL, 1); wr(A_SEL, 2); rd(A_SEL, d); chk("R2 sel=2->0", d, 0);
   endtask

   task automatic t_clamp();
      logic [31:0] d;
      wr(A_LEN0, 5000); rd(A_LEN0, d); chk("R3 clamp 5000", d, 4096);
      wr(A_LEN1, 4096); rd(A_LEN1, d); chk("R3 keep 4096", d, 4096);
      wr(A_LEN0, 100);  rd(A_LEN0, d); chk("R3 keep 100", d, 100);
      wr(A_LEN0, 0); wr(A_LEN1, 0);
   endtask

   task automatic t_gate();
      logic [31:0] d; int seen, n, e; bit fin;
      wr(A_CTRL, 0); wr(A_SEL, 0);
      push_words(8'h10, 2);
      wr(A_LEN0, 6); wr(A_GO0, 1);
      quiet(6, seen); chk("R5 no tx when disabled", seen, 0);
      rd(A_STAT, d); chk("R5 no status when disabled", d, 0);
      wr(A_CTRL, 2); wr(A_LEN0, 0); wr(A_GO0, 1);
      quiet(6, seen); chk("R5 no tx on zero length", seen, 0);
      wr(A_LEN0, 6); wr(A_GO0, 1);
      recv(1'b0, 0, n, fin);
      chk("R6 count min(len,held)", n, 6);
      chk("R6 last seen", fin, 1);
      pattern_errs(8'h10, n, e); chk("R4 R6 byte order", e, 0);
      chk("R6 chan tag", chan_err, 0);
      wr(A_STAT, 32'h1FF);
   endtask

   task automatic t_short();
      logic [31:0] d; int seen, n, e; bit fin;
      wr(A_SEL, 1);
      push_words(8'h40, 2);
      wr(A_LEN1, 12); wr(A_GO1, 1);
      recv(1'b1, 1, n, fin);
      chk("R6 truncated to held", n, 8);
      pattern_errs(8'h40, n, e); chk("R6 stalled data", e, 0);
      chk("R6 chan 1 tag", chan_err, 0);
      repeat (2) @(negedge clk);
      rd(A_LEN1, d); chk("R7 len cleared", d, 0);
      rd(A_STAT, d); chk("R7 status bit1", d, 32'h2);
      wr(A_STAT, 32'h2);
      wr(A_LEN1, 4); wr(A_GO1, 1);
      quiet(6, seen); chk("R7 flushed queue sends nothing", seen, 0);
      rd(A_STAT, d); chk("R7 empty completion status", d, 32'h2);
      wr(A_STAT, 32'h1FF);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(A_IEN, 0);
      pulse_rx();
      rd(A_STAT, d); chk("R8 rx sets bit8", d, 32'h100);
      chk("R9 irq masked", irq, 0);
      wr(A_IEN, 32'h100); #1ns chk("R9 irq enabled", irq, 1);
      wr(A_STAT, 32'h001);
      rd(A_STAT, d); chk("R8 other bit write keeps bit8", d, 32'h100);
      chk("R9 irq still high", irq, 1);
      wr(A_STAT, 32'h100);
      rd(A_STAT, d); chk("R8 w1c clears", d, 0);
      chk("R9 irq low", irq, 0);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h100; rx_event = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; rx_event = 1'b0;
      rd(A_STAT, d); chk("R8 set wins over clear", d, 32'h100);
      wr(A_STAT, 32'h1FF); wr(A_IEN, 0);
   endtask

   task automatic t_busy();
      logic [31:0] d; int seen, n, e; bit fin;
      tx_ready = 1'b0;
      wr(A_SEL, 0);
      push_words(8'h80, 2);
      wr(A_LEN0, 8); wr(A_GO0, 1);
      repeat (2) @(negedge clk);
      wr(A_LEN0, 4);
      wr(A_DATA, 32'hDEADBEEF);
      wr(A_GO0, 1);
      rd(A_LEN0, d); chk("R11 length write ignored while busy", d, 8);
      wr(A_SEL, 1);
      push_words(8'hC0, 1);
      wr(A_LEN1, 4); wr(A_GO1, 1);
      recv(1'b0, 0, n, fin);
      chk("R11 busy frame count", n, 8);
      pattern_errs(8'h80, n, e); chk("R11 busy frame data", e, 0);
      recv(1'b0, 1, n, fin);
      chk("R11 queued channel count", n, 4);
      pattern_errs(8'hC0, n, e); chk("R11 queued channel data", e, 0);
      chk("R11 queued channel tag", chan_err, 0);
      quiet(8, seen); chk("R11 repeated start ignored", seen, 0);
      rd(A_STAT, d); chk("R7 both status bits", d, 32'h3);
      wr(A_STAT, 32'h1FF);
   endtask

   task automatic t_overflow();
      int n, e; bit fin;
      wr(A_SEL, 0);
      push_words(8'h00, 1024);
      wr(A_DATA, 32'hDEADBEEF);
      wr(A_LEN0, 4096); wr(A_GO0, 1);
      recv(1'b0, 0, n, fin);
      chk("R4 full queue count", n, 4096);
      pattern_errs(8'h00, n, e); chk("R4 write to full queue dropped", e, 0);
      wr(A_STAT, 32'h1FF);
   endtask

   task automatic t_srst();
      logic [31:0] d; int seen;
      wr(A_SEL, 1);
      push_words(8'h20, 1);
      wr(A_LEN1, 4);
      wr(A_IEN, 32'h1FF);
      pulse_rx();
      chk("R9 irq before reset", irq, 1);
      wr(A_CTRL, 32'h7);
      rd(A_CTRL, d); chk("R10 ctrl bit0 self-clears", d, 32'h6);
      rd(A_SEL, d);  chk("R10 sel cleared", d, 0);
      rd(A_LEN1, d); chk("R10 len cleared", d, 0);
      rd(A_IEN, d);  chk("R10 ien cleared", d, 0);
      rd(A_STAT, d); chk("R10 stat cleared", d, 0);
      chk("R10 irq low", irq, 0);
      wr(A_LEN1, 4); wr(A_GO1, 1);
      quiet(6, seen); chk("R10 queue flushed", seen, 0);
      rd(A_STAT, d); chk("R10 R7 empty completion", d, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_select();
      t_clamp();
      t_gate();
      t_short();
      t_irq();
      t_busy();
      t_overflow();
      t_srst();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule